// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block keeps the per-channel pointer and counter state of a multi-channel DMA engine. Each channel has a source pointer, a destination pointer and a transfer counter. Each of these is loaded from an external reload latch value that arrives on the block's inputs. A one-cycle transfer-done strobe from the data mover moves both pointers by one step and lowers the counter by one.

When the counter is already at zero, the next transfer is an underflow. On an underflow the counter takes its latch value. The pointers also return to their latch values, unless a global reload-disable input is high. The channel also raises a sticky underflow flag and a one-cycle interrupt pulse. If the channel's auto-disable bit is set, the underflow clears the channel's enable.

Software can also reload all three registers at any time with a one-cycle reload command. That command overrides a transfer strobe that arrives in the same cycle.

Top module: `dma_addr_seq`

## Requirements
- R1: On each accepted transfer, each pointer moves according to its own 2-bit mode field. Code 2'b01 adds one and code 2'b10 subtracts one, both modulo 2^16. Codes 2'b00 and 2'b11 leave the pointer unchanged. Bits [2c+1:2c] of each mode input belong to channel c.
- R2: Each accepted transfer lowers the counter by one. A transfer that finds the counter at 0x0000 is an underflow, and the counter then takes its latch value instead of wrapping. A latch value of N therefore gives N+1 transfers per underflow; 0xFFFF gives 65,536.
- R3: On an underflow both pointers take their latch values when reload_dis is 0. When reload_dis is 1 they step per R1 instead. reload_dis acts on every channel.
- R4: The underflow flag is set by an underflow and stays set until uf_clr is 1 for that channel. If an underflow and a clear fall in the same cycle, the flag ends up set.
- R5: irq for a channel is high for exactly the one cycle after each underflow edge and low at all other times.
- R6: When auto_dis_en is 1, an underflow clears chan_en. If en_wr falls in the same cycle, the underflow still wins. In all other cycles en_wr loads en_wdata into chan_en.
- R7: A transfer strobe on a channel whose chan_en is 0 changes no pointer, counter, flag or irq.
- R8: reload_cmd loads both pointers and the counter from their latches on the next edge, whatever the value of reload_dis. When it coincides with a transfer strobe, the reload wins and no step or underflow occurs.
- R9: After reset all pointers and counters are 0x0000, and chan_en, uf_flag and irq are 0.
- R10: The channels are independent: the inputs of one channel never change the state of the other, except that reload_dis is shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_done | input | NCH | One-cycle transfer-done strobe per channel |
| reload_cmd | input | NCH | One-cycle software reload command per channel |
| reload_dis | input | 1 | Global: suppress pointer reload on underflow |
| src_mode | input | 2*NCH | Source pointer step mode per channel |
| dst_mode | input | 2*NCH | Destination pointer step mode per channel |
| auto_dis_en | input | NCH | Clear the enable on underflow |
| en_wr | input | NCH | Enable write strobe |
| en_wdata | input | NCH | Enable write value |
| uf_clr | input | NCH | Write-1 clear of the underflow flag |
| src_latch | input | PW*NCH | Source reload latch values |
| dst_latch | input | PW*NCH | Destination reload latch values |
| cnt_latch | input | CW*NCH | Counter reload latch values |
| src_ptr | output | PW*NCH | Current source pointers |
| dst_ptr | output | PW*NCH | Current destination pointers |
| count | output | CW*NCH | Current transfer counters |
| chan_en | output | NCH | Channel enables |
| uf_flag | output | NCH | Sticky underflow flags |
| irq | output | NCH | Underflow interrupt pulses |

## Verification
Two functions can fall on the same edge: the reload command and a transfer strobe that would underflow the counter. A flag clear or an enable write can also land on the same edge as an underflow. The bench provokes these collisions in a directed sequence at count zero, then again through dense random traffic with small latch counts so that underflows come often. A reference model in the bench applies the stated priorities (reload over transfer, set over clear, auto-disable over enable write). It compares every output on every cycle, so a wrong priority appears as a pointer, counter, flag or irq mismatch on the very next cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_HOLD2 = 2'b11
  } step_e;
endpackage

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] latch,
  output logic [PW-1:0] ptr
);
  import dma_seq_pkg::*;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p, input step_e m);
    case (m)
      STEP_INC: ptr_next = p + PW'(1);
      STEP_DEC: ptr_next = p - PW'(1);
      default:  ptr_next = p;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= latch;
    else if (step) ptr <= ptr_next(ptr, step_e'(mode));
  end
endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic [CW-1:0] latch,
  output logic [CW-1:0] cnt,
  output logic          uf
);
  function automatic logic cnt_empty(input logic [CW-1:0] v);
    cnt_empty = (v == '0);
  endfunction

  assign uf = dec && !load && cnt_empty(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load || uf)  cnt <= latch;
    else if (dec)         cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic uf,
  input  logic auto_dis,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic uf_clr,
  output logic en,
  output logic flag,
  output logic irq
);
  logic kill_en;
  assign kill_en = uf && auto_dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (kill_en)    en <= 1'b0;
      else if (en_wr) en <= en_wdata;
      if (uf)          flag <= 1'b1;
      else if (uf_clr) flag <= 1'b0;
      irq <= uf;
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter int NCH = 2,
  parameter int PW  = 16,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    xfer_done,
  input  logic [NCH-1:0]    reload_cmd,
  input  logic              reload_dis,
  input  logic [2*NCH-1:0]  src_mode,
  input  logic [2*NCH-1:0]  dst_mode,
  input  logic [NCH-1:0]    auto_dis_en,
  input  logic [NCH-1:0]    en_wr,
  input  logic [NCH-1:0]    en_wdata,
  input  logic [NCH-1:0]    uf_clr,
  input  logic [PW*NCH-1:0] src_latch,
  input  logic [PW*NCH-1:0] dst_latch,
  input  logic [CW*NCH-1:0] cnt_latch,
  output logic [PW*NCH-1:0] src_ptr,
  output logic [PW*NCH-1:0] dst_ptr,
  output logic [CW*NCH-1:0] count,
  output logic [NCH-1:0]    chan_en,
  output logic [NCH-1:0]    uf_flag,
  output logic [NCH-1:0]    irq
);
  // named internal events, visible to the checker
  logic [NCH-1:0] step_evt;
  logic [NCH-1:0] uf_evt;
  logic [NCH-1:0] ptr_load;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign step_evt[c] = xfer_done[c] && chan_en[c] && !reload_cmd[c];
    assign ptr_load[c] = reload_cmd[c] || (uf_evt[c] && !reload_dis);

    dma_ptr_unit #(.PW(PW)) u_src (
      .clk(clk), .rst_n(rst_n), .load(ptr_load[c]), .step(step_evt[c]),
      .mode(src_mode[2*c +: 2]), .latch(src_latch[c*PW +: PW]),
      .ptr(src_ptr[c*PW +: PW])
    );

    dma_ptr_unit #(.PW(PW)) u_dst (
      .clk(clk), .rst_n(rst_n), .load(ptr_load[c]), .step(step_evt[c]),
      .mode(dst_mode[2*c +: 2]), .latch(dst_latch[c*PW +: PW]),
      .ptr(dst_ptr[c*PW +: PW])
    );

    dma_cnt_unit #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(reload_cmd[c]), .dec(step_evt[c]),
      .latch(cnt_latch[c*CW +: CW]), .cnt(count[c*CW +: CW]),
      .uf(uf_evt[c])
    );

    dma_chan_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .uf(uf_evt[c]), .auto_dis(auto_dis_en[c]),
      .en_wr(en_wr[c]), .en_wdata(en_wdata[c]), .uf_clr(uf_clr[c]),
      .en(chan_en[c]), .flag(uf_flag[c]), .irq(irq[c])
    );
  end
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int NCH = 2,
  parameter int PW  = 16,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    xfer_done,
  input logic [NCH-1:0]    reload_cmd,
  input logic              reload_dis,
  input logic [NCH-1:0]    auto_dis_en,
  input logic [NCH-1:0]    uf_clr,
  input logic [PW*NCH-1:0] src_latch,
  input logic [CW*NCH-1:0] cnt_latch,
  input logic [PW*NCH-1:0] src_ptr,
  input logic [CW*NCH-1:0] count,
  input logic [NCH-1:0]    chan_en,
  input logic [NCH-1:0]    uf_flag,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    step_evt,
  input logic [NCH-1:0]    uf_evt
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R5
    irq_after_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt[c] |=> irq[c]);
    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !uf_evt[c] |=> !irq[c]);
    // R2
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_evt[c] && !uf_evt[c] |=> count[c*CW +: CW] == $past(count[c*CW +: CW]) - CW'(1));
    // R6
    auto_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt[c] && auto_dis_en[c] |=> !chan_en[c]);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done[c] && !chan_en[c] && !reload_cmd[c]
      |=> $stable(count[c*CW +: CW]) && $stable(src_ptr[c*PW +: PW]));
    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_flag[c] && !uf_clr[c] |=> uf_flag[c]);
    // R8
    reload_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload_cmd[c] |=> count[c*CW +: CW] == $past(cnt_latch[c*CW +: CW]));
    // R3
    uf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt[c] && !reload_dis |=> src_ptr[c*PW +: PW] == $past(src_latch[c*PW +: PW]));
  end
endmodule

bind dma_addr_seq dma_seq_chk #(.NCH(NCH), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .reload_cmd(reload_cmd),
  .reload_dis(reload_dis), .auto_dis_en(auto_dis_en), .uf_clr(uf_clr),
  .src_latch(src_latch), .cnt_latch(cnt_latch), .src_ptr(src_ptr),
  .count(count), .chan_en(chan_en), .uf_flag(uf_flag), .irq(irq),
  .step_evt(step_evt), .uf_evt(uf_evt)
);

// File: tb/sim_dma_addr_seq.sv
`timescale 1ns/1ps
module sim_dma_addr_seq;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  xfer_done = '0, reload_cmd = '0, auto_dis_en = '0;
  logic [1:0]  en_wr = '0, en_wdata = '0, uf_clr = '0;
  logic        reload_dis = 1'b0;
  logic [3:0]  src_mode = '0, dst_mode = '0;
  logic [31:0] src_latch = '0, dst_latch = '0, cnt_latch = '0;
  logic [31:0] src_ptr, dst_ptr, count;
  logic [1:0]  chan_en, uf_flag, irq;

  dma_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .reload_cmd(reload_cmd),
    .reload_dis(reload_dis), .src_mode(src_mode), .dst_mode(dst_mode),
    .auto_dis_en(auto_dis_en), .en_wr(en_wr), .en_wdata(en_wdata),
    .uf_clr(uf_clr), .src_latch(src_latch), .dst_latch(dst_latch),
    .cnt_latch(cnt_latch), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .count(count), .chan_en(chan_en), .uf_flag(uf_flag), .irq(irq)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int irq_total = 0;
  bit done = 0;

  // reference model state
  int s_m[NCH], d_m[NCH], c_m[NCH];
  bit en_m[NCH], f_m[NCH], i_m[NCH];

  function automatic int mv(int p, logic [1:0] m);
    if (m == 2'd1) return (p + 1) % 65536;
    if (m == 2'd2) return (p == 0) ? 65535 : p - 1;
    return p;
  endfunction

  task automatic cmp(string tag, int ch, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s ch%0d actual=%h expected=%h at %0t", tag, ch, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int ch = 0; ch < NCH; ch++) begin
      cmp("R1/R3/R8/R10 src", ch, int'(src_ptr[ch*16 +: 16]), s_m[ch]);
      cmp("R1/R3/R8/R10 dst", ch, int'(dst_ptr[ch*16 +: 16]), d_m[ch]);
      cmp("R2/R7/R8 count",   ch, int'(count[ch*16 +: 16]), c_m[ch]);
      cmp("R6 chan_en",       ch, int'(chan_en[ch]), int'(en_m[ch]));
      cmp("R4 uf_flag",       ch, int'(uf_flag[ch]), int'(f_m[ch]));
      cmp("R5 irq",           ch, int'(irq[ch]), int'(i_m[ch]));
      if (irq[ch]) irq_total++;
    end
  endtask

  // next state from current model state and the inputs now on the pins
  task automatic model_step();
    for (int ch = 0; ch < NCH; ch++) begin
      bit uf = 0;
      int sl = int'(src_latch[ch*16 +: 16]);
      int dl = int'(dst_latch[ch*16 +: 16]);
      int cl = int'(cnt_latch[ch*16 +: 16]);
      if (reload_cmd[ch]) begin          // R8 reload wins
        s_m[ch] = sl; d_m[ch] = dl; c_m[ch] = cl;
      end else if (xfer_done[ch] && en_m[ch]) begin
        if (c_m[ch] == 0) begin          // R2 underflow
          uf = 1;
          c_m[ch] = cl;
          if (!reload_dis) begin s_m[ch] = sl; d_m[ch] = dl; end
          else begin
            s_m[ch] = mv(s_m[ch], src_mode[2*ch +: 2]);
            d_m[ch] = mv(d_m[ch], dst_mode[2*ch +: 2]);
          end
        end else begin
          c_m[ch] = c_m[ch] - 1;
          s_m[ch] = mv(s_m[ch], src_mode[2*ch +: 2]);
          d_m[ch] = mv(d_m[ch], dst_mode[2*ch +: 2]);
        end
      end
      if (uf && auto_dis_en[ch]) en_m[ch] = 0;
      else if (en_wr[ch]) en_m[ch] = en_wdata[ch];
      if (uf) f_m[ch] = 1;
      else if (uf_clr[ch]) f_m[ch] = 0;
      i_m[ch] = uf;
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    xfer_done = '0; reload_cmd = '0; en_wr = '0; uf_clr = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int irq_before;
    for (int ch = 0; ch < NCH; ch++) begin
      s_m[ch] = 0; d_m[ch] = 0; c_m[ch] = 0; en_m[ch] = 0; f_m[ch] = 0; i_m[ch] = 0;
    end
    repeat (3) @(negedge clk);
    compare_all();                       // R9 reset state
    rst_n = 1'b1;

    // directed: load ch0, enable, underflow with reload
    src_latch = 32'h0000_1000; dst_latch = 32'h0000_2000; cnt_latch = 32'h0005_0002;
    reload_cmd = 2'b01; tick(); quiet();
    en_wr = 2'b01; en_wdata = 2'b01; tick(); quiet();
    src_mode = 4'b1001; dst_mode = 4'b0110;        // R1 ch0 src inc, dst dec
    xfer_done = 2'b11; tick(); tick(); tick();      // R7 ch1 still disabled
    quiet(); tick();
    // R8 reload coinciding with a transfer at count zero
    xfer_done = 2'b01; tick(); tick();
    reload_cmd = 2'b01; tick(); quiet();
    // R4/R6 clear and enable write coinciding with underflow
    auto_dis_en = 2'b01; xfer_done = 2'b01; tick(); tick();
    uf_clr = 2'b01; en_wr = 2'b01; en_wdata = 2'b01; tick(); quiet();
    tick(); tick();

    // random traffic with small counts
    for (int n = 0; n < 4000; n++) begin
      xfer_done  = 2'($urandom);
      reload_cmd = {($urandom % 24) == 0, ($urandom % 24) == 0};
      en_wr      = {($urandom % 8) == 0, ($urandom % 8) == 0};
      en_wdata   = {($urandom % 4) != 0, ($urandom % 4) != 0};
      uf_clr     = {($urandom % 6) == 0, ($urandom % 6) == 0};
      auto_dis_en = 2'($urandom);
      if ((n % 97) == 0) reload_dis = 1'($urandom);
      src_mode   = 4'($urandom); dst_mode = 4'($urandom);
      src_latch  = $urandom; dst_latch = $urandom;
      cnt_latch  = {13'd0, 3'($urandom), 13'd0, 3'($urandom)};
      tick();
    end
    quiet();

    // R2 full-range count: latch 0xFFFF gives 65,536 transfers, R3 with reload disabled
    reload_dis = 1'b1; auto_dis_en = '0; src_mode = 4'b0001; dst_mode = 4'b0000;
    cnt_latch = 32'h0000_FFFF; src_latch = 32'h0000_0100;
    reload_cmd = 2'b01; en_wr = 2'b01; en_wdata = 2'b01; tick(); quiet();
    irq_before = irq_total;
    xfer_done = 2'b01;
    for (int n = 0; n < 65535; n++) tick();
    cmp("R2 no irq before 65536th", 0, irq_total - irq_before, 0);
    tick();
    quiet(); tick();
    cmp("R2 irq at 65536th", 0, irq_total - irq_before, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule